// File: doc/BRIEF.md
# NAND Bus Strobe Toggle Engine

This block drives the five control pins of a NAND flash bus by alternating between two 5-bit pin vectors. A command sequencer places an active vector, an idle vector and a repeat limit on the inputs, then raises `en`. The engine captures all three values. It holds the active vector for four clock cycles and the idle vector for two. At a 100 MHz clock this gives a 60 ns period in which the pins spend one third of the time in the second vector.

The six-cycle period repeats `rep_limit + 1` times. After the last period the engine raises `done` and holds it until the sequencer drops `en`. The read strobe rises at the step from the first vector to the second. A one-cycle `sample` pulse marks the last cycle of each low phase, so that the data path can capture read data at that rising edge, which leaves 5 ns of margin over a 35 ns access time.

While idle, the pins follow the live idle vector input, which the sequencer keeps at an inactive pattern. Command decoding, page buffers and the host interface live elsewhere.

Top module: `nand_strobe_engine`

## Requirements
- R1: While idle (after reset, or once `en` has been low in the done state), `pins` equals the `vec_b` input in the same cycle, and `done` and `sample` are 0.
- R2: When `en` is sampled high while idle, `pins` shows the captured `vec_a` from the next cycle on.
- R3: Each period is six cycles: four with `pins` equal to the captured `vec_a`, then two with `pins` equal to the captured `vec_b`. The pin bits are bit 4 chip enable, bit 3 command latch, bit 2 address latch, bit 1 write strobe and bit 0 read strobe.
- R4: Exactly `rep_limit + 1` periods run back to back. `done` rises in the cycle after the last cycle of the final period.
- R5: `sample` is high for exactly one cycle per period, on the fourth cycle of the first-vector phase, and is low at every other time.
- R6: While `done` is high and `en` stays high, `done` stays high and `pins` equals the captured `vec_b`.
- R7: When `en` is low in the done state, the engine is idle in the next cycle.
- R8: `vec_a`, `vec_b` and `rep_limit` are captured when a run starts. Changing them during the run affects neither the pin pattern nor the number of periods.
- R9: An active-low `rst_n` forces the idle state at once, even in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Start request from the sequencer; must be dropped to leave the done state |
| vec_a | input | 5 | Pin vector for the four-cycle phase |
| vec_b | input | 5 | Pin vector for the two-cycle phase and for idle |
| rep_limit | input | CNT_W | Number of periods minus one |
| pins | output | 5 | NAND control pins: {chip enable, command latch, address latch, write strobe, read strobe} |
| sample | output | 1 | One-cycle read-capture pulse before the read strobe rises |
| done | output | 1 | Run finished |

## Verification
Every run uses a pair of vectors that differ in every bit, so if one vector is shown in place of the other, all five pins are wrong. A limit of 0 gives a single period and a limit of 3 gives several; together they expose an off-by-one in the repeat count, and the largest limit exposes counter wrap. One run changes all three inputs after it has started, which shows whether the engine captured them. A reset in the middle of a burst and a long hold in the done state check that the engine enters and leaves its idle state correctly.

// File: rtl/nse_pkg.sv
package nse_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_FIN  = 2'd3
  } nse_state_t;

  // cycles in one full strobe period
  function automatic int nse_period(input int low_cyc, input int high_cyc);
    return low_cyc + high_cyc;
  endfunction

  // number of periods a given limit produces
  function automatic int nse_burst_len(input int limit);
    return limit + 1;
  endfunction

endpackage

// File: rtl/nse_phase_ctr.sv
module nse_phase_ctr #(
  parameter int LOW_CYC  = 4,
  parameter int HIGH_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic low_last,
  output logic period_end
);
  localparam int PERIOD = nse_pkg::nse_period(LOW_CYC, HIGH_CYC);
  localparam int DLY_W  = $clog2(PERIOD);
  localparam logic [DLY_W-1:0] LOW_LAST_V = DLY_W'(LOW_CYC - 1);
  localparam logic [DLY_W-1:0] PER_LAST_V = DLY_W'(PERIOD - 1);

  logic [DLY_W-1:0] dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dly_q <= '0;
    else if (!run || dly_q == PER_LAST_V)
      dly_q <= '0;
    else
      dly_q <= dly_q + 1'b1;
  end

  assign low_last   = run && (dly_q == LOW_LAST_V);
  assign period_end = run && (dly_q == PER_LAST_V);
endmodule

// File: rtl/nse_rep_ctr.sv
module nse_rep_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             at_limit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr)
      cnt <= '0;
    else if (inc && !at_limit)
      cnt <= cnt + 1'b1;
  end

  assign at_limit = (cnt == limit);
endmodule

// File: rtl/nse_pin_mux.sv
module nse_pin_mux #(
  parameter int PIN_W = 5
) (
  input  logic             sel_idle,
  input  logic             sel_a,
  input  logic [PIN_W-1:0] live_b,
  input  logic [PIN_W-1:0] a_q,
  input  logic [PIN_W-1:0] b_q,
  output logic [PIN_W-1:0] pins
);
  for (genvar i = 0; i < PIN_W; i++) begin : g_bit
    assign pins[i] = sel_idle ? live_b[i] : (sel_a ? a_q[i] : b_q[i]);
  end
endmodule

// File: rtl/nand_strobe_engine.sv
module nand_strobe_engine #(
  parameter int PIN_W    = 5,
  parameter int CNT_W    = 8,
  parameter int LOW_CYC  = 4,
  parameter int HIGH_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PIN_W-1:0] vec_a,
  input  logic [PIN_W-1:0] vec_b,
  input  logic [CNT_W-1:0] rep_limit,
  output logic [PIN_W-1:0] pins,
  output logic             sample,
  output logic             done
);
  import nse_pkg::*;

  nse_state_t       st, st_nx;
  logic [PIN_W-1:0] a_q, b_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] rep_cnt;
  logic             running, low_last, period_end, at_limit, start;

  assign running = (st == ST_LOW) || (st == ST_HIGH);
  assign start   = (st == ST_IDLE) && en;

  nse_phase_ctr #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(running),
    .low_last(low_last), .period_end(period_end)
  );

  nse_rep_ctr #(.CNT_W(CNT_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .clr(st == ST_IDLE), .inc(period_end),
    .limit(lim_q), .cnt(rep_cnt), .at_limit(at_limit)
  );

  nse_pin_mux #(.PIN_W(PIN_W)) u_mux (
    .sel_idle(st == ST_IDLE), .sel_a(st == ST_LOW), .live_b(vec_b),
    .a_q(a_q), .b_q(b_q), .pins(pins)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (en)         st_nx = ST_LOW;
      ST_LOW:  if (low_last)   st_nx = ST_HIGH;
      ST_HIGH: if (period_end) st_nx = at_limit ? ST_FIN : ST_LOW;
      ST_FIN:  if (!en)        st_nx = ST_IDLE;
      default:                 st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      a_q   <= '0;
      b_q   <= '0;
      lim_q <= '0;
    end else begin
      st <= st_nx;
      if (start) begin
        a_q   <= vec_a;
        b_q   <= vec_b;
        lim_q <= rep_limit;
      end
    end
  end

  assign sample = low_last;
  assign done   = (st == ST_FIN);
endmodule

// File: rtl/nse_checker.sv
module nse_checker #(
  parameter int PIN_W = 5,
  parameter int CNT_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               sample,
  input logic               done,
  input nse_pkg::nse_state_t st,
  input logic [PIN_W-1:0]   a_q,
  input logic [CNT_W-1:0]   lim_q,
  input logic [CNT_W-1:0]   rep_cnt
);
  import nse_pkg::*;

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && en) |=> (st == ST_LOW));  // R2

  AST_HIGH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_HIGH) |=> (st == ST_HIGH));  // R3

  AST_REP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |-> (rep_cnt <= lim_q));  // R4

  AST_SAMPLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> !sample);  // R5

  AST_SAMPLE_BEFORE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_HIGH) |-> $past(sample));  // R5

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && en) |=> done);  // R6

  AST_DONE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !en) |=> (st == ST_IDLE));  // R7

  AST_CAPTURE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOW || st == ST_HIGH) |=> ($stable(a_q) && $stable(lim_q)));  // R8
endmodule

bind nand_strobe_engine nse_checker #(.PIN_W(PIN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sample(sample), .done(done),
  .st(st), .a_q(a_q), .lim_q(lim_q), .rep_cnt(rep_cnt)
);

// File: tb/nand_strobe_engine_test.sv
`timescale 1ns/1ps
module nand_strobe_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [4:0] vec_a = '0;
  logic [4:0] vec_b = 5'h1f;
  logic [7:0] rep_limit = '0;
  logic [4:0] pins;
  logic       sample, done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nand_strobe_engine uut (
    .clk(clk), .rst_n(rst_n), .en(en), .vec_a(vec_a), .vec_b(vec_b),
    .rep_limit(rep_limit), .pins(pins), .sample(sample), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  task automatic idle_expect(input string req);
    check(req, pins, vec_b);
    check(req, done, 0);
    check(req, sample, 0);
  endtask

  // one burst; if upset, the inputs are changed after the run has started (R8)
  task automatic run_burst(input logic [4:0] a, input logic [4:0] b,
                           input int lim, input bit upset);
    int n = (lim + 1) * 6;
    @(negedge clk);
    vec_a = a; vec_b = b; rep_limit = 8'(lim); en = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      check((k < 6) ? "R2" : "R3", pins, ((k % 6) < 4) ? a : b);
      check("R5", sample, ((k % 6) == 3) ? 1 : 0);
      check("R4", done, 0);
      if (upset && k == 7) begin
        vec_a = ~a; vec_b = ~b; rep_limit = 8'd0;
      end
    end
    for (int h = 0; h < 3; h++) begin
      @(negedge clk); #1;
      check("R4", done, 1);
      check("R6", pins, b);
      check("R6", sample, 0);
    end
    en = 1'b0;
    @(negedge clk); #1;
    idle_expect("R7");
  endtask

  task automatic test_idle_follow();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      vec_b = 5'(3 + 7 * i);
      vec_a = ~vec_b;
      #1 idle_expect("R1");
    end
  endtask

  task automatic test_reset_midrun();
    @(negedge clk);
    vec_a = 5'h0a; vec_b = 5'h15; rep_limit = 8'd5; en = 1'b1;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1 idle_expect("R9");
    en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    idle_expect("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 idle_expect("R1");
    rst_n = 1'b1;
    @(negedge clk); #1;
    idle_expect("R1");
    test_idle_follow();
    run_burst(5'b01110, 5'b10001, 0, 0);
    run_burst(5'b10101, 5'b01010, 3, 0);
    run_burst(5'b00000, 5'b11111, 2, 1);
    test_reset_midrun();
    run_burst(5'b11100, 5'b00011, 255, 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule